// File: doc/BRIEF.md
# Frame Engine Control Register Bank

This block is the software-facing register slave of a video frame-processing engine. A host writes and reads 32-bit words over a simple strobe bus. A write presents address and data together with a write strobe. A read presents an address with a read strobe, and the data appears on the following cycle. The bank passes the frame geometry, two 64-bit buffer base addresses, a colour-format code, an algorithm code and a field-polarity invert bit to the engine. It also holds the engine's start request.

The engine reports completion, idleness and acceptance of a start back to the bank. The control bits have different access rules. Start stays set until the engine takes it. Done is sticky until it is read. Auto-restart requests a new start by itself after each completion. A two-source interrupt block with a global gate drives a level interrupt. The status bits of that block are flipped by writing ones to them. The algorithm codes are median (0x00), bob (0x01), weave (0x02), vertical-temporal interpolation (0x03) and pass-through (0x06). The bank stores the code and the engine decodes it.

Top module: `frame_engine_csr`

## Requirements
- R1: After reset every register reads zero, except the control word, which reads 0x00000004 (idle set). The start output and the interrupt output are 0.
- R2: Width (offset 0x010, bits 15:0), height (0x018, bits 15:0), colour format (0x030, bits 7:0), algorithm (0x038, bits 7:0) and field invert (0x040, bit 0) each store the written bits. Each drives its output and reads back, with the unused upper bits read as zero.
- R3: The read-buffer base is 64 bits, with the low word at 0x020 and the high word at 0x024. The write-buffer base is 64 bits, with the low word at 0x050 and the high word at 0x054. Each word is written and read independently.
- R4: A write to 0x000 with bit 0 equal to 1 sets start (control bit 0). Writing 0 to that bit has no effect. Start clears in the cycle after the engine signals ready. A set request in the same cycle as ready wins.
- R5: Control bit 1 (done) is set by an engine done pulse and holds until a read of 0x000. That read returns the value before the clear. A done pulse in the same cycle as the read leaves done set.
- R6: Control bit 2 (idle) reads 1 until start has first been set. After that it reflects the engine idle input at the read cycle. Control bit 3 (ready) reflects the engine ready input at the read cycle.
- R7: When control bit 7 (auto-restart) is 1, an engine done pulse sets start on the next cycle.
- R8: Interrupt status at 0x00C (bit 0 done, bit 1 ready) sets when its event occurs while the matching enable at 0x008 is 1. Writing 1 to a status bit inverts it, and writing 0 leaves it unchanged.
- R9: The interrupt output equals the global enable (0x004 bit 0) ANDed with the OR of status bits ANDed with their enables.
- R10: Reads of unmapped offsets return zero, and writes to them change nothing. Read data is zero in any cycle after a cycle with no read.
- R11: Writes to the read-only control bits 1, 2 and 3 have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read byte offset |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| eng_done | input | 1 | Engine finished a frame (pulse) |
| eng_idle | input | 1 | Engine idle level |
| eng_ready | input | 1 | Engine accepted start (pulse) |
| eng_start | output | 1 | Start request to the engine |
| cfg_width | output | 16 | Frame width |
| cfg_height | output | 16 | Frame height |
| cfg_rd_base | output | 64 | Read buffer base address |
| cfg_wr_base | output | 64 | Write buffer base address |
| cfg_format | output | 8 | Colour format code |
| cfg_algo | output | 8 | Algorithm select code |
| cfg_field_inv | output | 1 | Field polarity invert |
| irq | output | 1 | Level interrupt |

## Verification
A behavioural model in the bench tracks every register and is compared with the outputs on every clock. The scenarios separate the set and clear paths of each bit. Start is tested against a ready pulse alone and against a ready pulse that coincides with a write, which shows whether set takes priority. Done is tested with a lone read and with a read that coincides with a completion pulse, which shows whether an event can be lost. Status bits are driven both by events and by toggle writes with each enable on and off, which shows whether the gating sits before or after the status bits. Writes of ones to read-only and unmapped locations show that they cannot leak into stored state.

// File: rtl/frame_engine_csr.sv
module frame_engine_csr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic          eng_done,
  input  logic          eng_idle,
  input  logic          eng_ready,
  output logic          eng_start,
  output logic [15:0]   cfg_width,
  output logic [15:0]   cfg_height,
  output logic [63:0]   cfg_rd_base,
  output logic [63:0]   cfg_wr_base,
  output logic [7:0]    cfg_format,
  output logic [7:0]    cfg_algo,
  output logic          cfg_field_inv,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTL = AW'('h000), A_GIE = AW'('h004), A_IER = AW'('h008),
    A_ISR = AW'('h00C), A_WID = AW'('h010), A_HGT = AW'('h018), A_RB0 = AW'('h020),
    A_RB1 = AW'('h024), A_FMT = AW'('h030), A_ALG = AW'('h038), A_INV = AW'('h040),
    A_WB0 = AW'('h050), A_WB1 = AW'('h054);

  logic start_q, done_q, auto_q, seen_q, gie_q;
  logic [1:0] ier_q, isr_q;
  logic [31:0] rmux;

  wire wr_ctl = wr_en && wr_addr == A_CTL;
  wire wr_isr = wr_en && wr_addr == A_ISR;
  wire rd_ctl = rd_en && rd_addr == A_CTL;
  wire idle_v = (seen_q || start_q) ? eng_idle : 1'b1;

  assign eng_start = start_q;
  assign irq = gie_q && |(isr_q & ier_q);

  always_comb begin
    rmux = '0;
    case (rd_addr)
      A_CTL: rmux = {24'd0, auto_q, 3'd0, eng_ready, idle_v, done_q, start_q};
      A_GIE: rmux[0] = gie_q;
      A_IER: rmux[1:0] = ier_q;
      A_ISR: rmux[1:0] = isr_q;
      A_WID: rmux[15:0] = cfg_width;
      A_HGT: rmux[15:0] = cfg_height;
      A_RB0: rmux = cfg_rd_base[31:0];
      A_RB1: rmux = cfg_rd_base[63:32];
      A_FMT: rmux[7:0] = cfg_format;
      A_ALG: rmux[7:0] = cfg_algo;
      A_INV: rmux[0] = cfg_field_inv;
      A_WB0: rmux = cfg_wr_base[31:0];
      A_WB1: rmux = cfg_wr_base[63:32];
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0; done_q <= 1'b0; auto_q <= 1'b0; seen_q <= 1'b0;
      gie_q <= 1'b0; ier_q <= '0; isr_q <= '0; rd_data <= '0;
      cfg_width <= '0; cfg_height <= '0; cfg_rd_base <= '0; cfg_wr_base <= '0;
      cfg_format <= '0; cfg_algo <= '0; cfg_field_inv <= 1'b0;
    end else begin
      start_q <= (start_q && !eng_ready) || (wr_ctl && wr_data[0]) || (auto_q && eng_done);
      done_q  <= (done_q && !rd_ctl) || eng_done;
      if (start_q) seen_q <= 1'b1;
      if (wr_ctl) auto_q <= wr_data[7];
      isr_q <= (isr_q ^ (wr_isr ? wr_data[1:0] : 2'b00)) | ({eng_ready, eng_done} & ier_q);
      rd_data <= rd_en ? rmux : '0;
      if (wr_en) begin
        case (wr_addr)
          A_GIE: gie_q <= wr_data[0];
          A_IER: ier_q <= wr_data[1:0];
          A_WID: cfg_width <= wr_data[15:0];
          A_HGT: cfg_height <= wr_data[15:0];
          A_RB0: cfg_rd_base[31:0] <= wr_data;
          A_RB1: cfg_rd_base[63:32] <= wr_data;
          A_FMT: cfg_format <= wr_data[7:0];
          A_ALG: cfg_algo <= wr_data[7:0];
          A_INV: cfg_field_inv <= wr_data[0];
          A_WB0: cfg_wr_base[31:0] <= wr_data;
          A_WB1: cfg_wr_base[63:32] <= wr_data;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/frame_engine_csr_chk.sv
module frame_engine_csr_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic [31:0]   rd_data,
  input logic          eng_done,
  input logic          eng_ready,
  input logic          eng_start,
  input logic          auto_q,
  input logic          done_q,
  input logic [1:0]    isr_q,
  input logic [1:0]    ier_q,
  input logic [15:0]   cfg_width
);
  wire set_req = (wr_en && wr_addr == AW'('h000) && wr_data[0]) || (auto_q && eng_done);

  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start && eng_ready && !set_req |=> !eng_start);
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> done_q);
  a_r7_auto_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    auto_q && eng_done |=> eng_start);
  a_r8_isr_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == AW'('h00C) && wr_data[0] && !(eng_done && ier_q[0])
      |=> isr_q[0] != $past(isr_q[0]));
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (rd_addr == AW'('h014) || rd_addr == AW'('h058)) |=> rd_data == 32'd0);
  a_r2_width_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_width));
endmodule

bind frame_engine_csr frame_engine_csr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .eng_done(eng_done),
  .eng_ready(eng_ready), .eng_start(eng_start), .auto_q(auto_q), .done_q(done_q),
  .isr_q(isr_q), .ier_q(ier_q), .cfg_width(cfg_width)
);

// File: tb/tb_frame_engine_csr.sv
module tb_frame_engine_csr;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, eng_done = 0, eng_idle = 1, eng_ready = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic eng_start, cfg_field_inv, irq;
  logic [15:0] cfg_width, cfg_height;
  logic [63:0] cfg_rd_base, cfg_wr_base;
  logic [7:0] cfg_format, cfg_algo;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  frame_engine_csr #(.AW(AW)) dut (.*);

  // behavioural reference model
  bit m_start, m_done, m_auto, m_seen, m_gie, m_inv;
  bit [1:0] m_ier, m_isr;
  bit [15:0] m_w, m_h;
  bit [63:0] m_rb, m_wb;
  bit [7:0] m_fmt, m_alg;
  bit [31:0] m_rd;

  function automatic bit [31:0] m_read(int a);
    case (a)
      'h00: return {24'd0, m_auto, 3'd0, eng_ready, (m_seen || m_start) ? eng_idle : 1'b1, m_done, m_start};
      'h04: return {31'd0, m_gie};
      'h08: return {30'd0, m_ier};
      'h0C: return {30'd0, m_isr};
      'h10: return {16'd0, m_w};
      'h18: return {16'd0, m_h};
      'h20: return m_rb[31:0];
      'h24: return m_rb[63:32];
      'h30: return {24'd0, m_fmt};
      'h38: return {24'd0, m_alg};
      'h40: return {31'd0, m_inv};
      'h50: return m_wb[31:0];
      'h54: return m_wb[63:32];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = 0; m_done = 0; m_auto = 0; m_seen = 0; m_gie = 0; m_inv = 0;
      m_ier = 0; m_isr = 0; m_w = 0; m_h = 0; m_rb = 0; m_wb = 0; m_fmt = 0; m_alg = 0; m_rd = 0;
    end else begin
      bit ns, nd, na;
      bit [1:0] ni;
      m_rd = rd_en ? m_read(int'(rd_addr)) : 0;
      ns = m_start;
      if (eng_ready) ns = 0;
      if (wr_en && wr_addr == 0 && wr_data[0]) ns = 1;
      if (m_auto && eng_done) ns = 1;
      nd = m_done;
      if (rd_en && rd_addr == 0) nd = 0;
      if (eng_done) nd = 1;
      na = (wr_en && wr_addr == 0) ? wr_data[7] : m_auto;
      ni = m_isr;
      if (wr_en && wr_addr == 'h0C) ni = ni ^ wr_data[1:0];
      if (eng_done && m_ier[0]) ni[0] = 1;
      if (eng_ready && m_ier[1]) ni[1] = 1;
      if (m_start) m_seen = 1;
      if (wr_en) begin
        case (int'(wr_addr))
          'h04: m_gie = wr_data[0];
          'h08: m_ier = wr_data[1:0];
          'h10: m_w = wr_data[15:0];
          'h18: m_h = wr_data[15:0];
          'h20: m_rb[31:0] = wr_data;
          'h24: m_rb[63:32] = wr_data;
          'h30: m_fmt = wr_data[7:0];
          'h38: m_alg = wr_data[7:0];
          'h40: m_inv = wr_data[0];
          'h50: m_wb[31:0] = wr_data;
          'h54: m_wb[63:32] = wr_data;
          default: ;
        endcase
      end
      m_start = ns; m_done = nd; m_auto = na; m_isr = ni;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R4 start output vs model", eng_start, m_start);
    chk("R9 irq vs model", irq, m_gie && |(m_isr & m_ier));
    chk("R10 rd_data vs model", rd_data, m_rd);
    chk("R2 width vs model", cfg_width, m_w);
    chk("R2 height vs model", cfg_height, m_h);
    chk("R3 read base vs model", cfg_rd_base, m_rb);
    chk("R3 write base vs model", cfg_wr_base, m_wb);
    chk("R2 format/algo/invert vs model", {cfg_format, cfg_algo, cfg_field_inv}, {m_fmt, m_alg, m_inv});
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk); rd_en = 1; rd_addr = AW'(a);
    @(negedge clk); rd_en = 0;
    chk(tag, rd_data, exp);
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1; @(negedge clk); eng_done = 0;
  endtask

  task automatic pulse_ready();
    @(negedge clk); eng_ready = 1; @(negedge clk); eng_ready = 0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 start after reset", eng_start, 0);
    chk("R1 irq after reset", irq, 0);
    rd('h00, 32'h4, "R1 control reset");
    rd('h0C, 0, "R1 status reset");
    rd('h24, 0, "R1 read base high reset");
    // R2 / R3 configuration
    wr('h10, 32'hABCD_1234); rd('h10, 32'h1234, "R2 width upper bits zero");
    wr('h18, 32'hFFFF_0438); rd('h18, 32'h0438, "R2 height");
    wr('h30, 32'h1FF);       rd('h30, 32'hFF, "R2 format");
    wr('h38, 32'h0000_0106); rd('h38, 32'h06, "R2 algorithm pass-through");
    wr('h40, 32'h3);         rd('h40, 32'h1, "R2 invert");
    wr('h20, 32'h1111_2222); wr('h24, 32'h3333_4444);
    wr('h50, 32'h5555_6666); wr('h54, 32'h7777_8888);
    chk("R3 read base value", cfg_rd_base, 64'h3333_4444_1111_2222);
    rd('h54, 32'h7777_8888, "R3 write base high");
    // R10 unmapped
    wr('h14, 32'hFFFF_FFFF); wr('h58, 32'hFFFF_FFFF); wr('h2C, 32'hFFFF_FFFF);
    rd('h14, 0, "R10 reserved read"); rd('h2C, 0, "R10 unmapped read");
    chk("R10 width untouched by unmapped writes", cfg_width, 16'h1234);
    // R11 read-only control bits
    wr('h00, 32'h0E); rd('h00, 32'h4, "R11 read-only bits unchanged");
    // R4 start
    wr('h00, 32'h1); chk("R4 start set", eng_start, 1);
    wr('h00, 32'h0); chk("R4 zero write no clear", eng_start, 1);
    eng_idle = 0;
    rd('h00, 32'h1, "R6 idle follows engine after start");
    pulse_ready(); chk("R4 cleared by ready", eng_start, 0);
    @(negedge clk); eng_ready = 1; wr_en = 1; wr_addr = 0; wr_data = 1;
    @(negedge clk); eng_ready = 0; wr_en = 0;
    chk("R4 set wins over ready", eng_start, 1);
    pulse_ready();
    // R6 ready bit
    @(negedge clk); eng_ready = 1; rd_en = 1; rd_addr = 0;
    @(negedge clk); eng_ready = 0; rd_en = 0;
    chk("R6 ready bit visible", rd_data, 32'h8);
    // R5 done
    pulse_done();
    rd('h00, 32'h2, "R5 done sticky");
    rd('h00, 32'h0, "R5 done cleared by read");
    @(negedge clk); eng_done = 1; rd_en = 1; rd_addr = 0;
    @(negedge clk); eng_done = 0; rd_en = 0;
    chk("R5 read during done returns old", rd_data, 0);
    rd('h00, 32'h2, "R5 done kept over coincident read");
    eng_idle = 1;
    // R7 auto-restart
    wr('h00, 32'h80); chk("R7 auto alone no start", eng_start, 0);
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    chk("R7 rearmed after done", eng_start, 1);
    pulse_ready();
    wr('h00, 32'h0); rd('h00, 32'h6, "R7 auto cleared, done and idle");
    rd('h00, 32'h4, "R5 control after clear");
    // R8 / R9 interrupts
    wr('h08, 32'h3);
    pulse_done();
    rd('h0C, 32'h1, "R8 status set by enabled done");
    chk("R9 gated off by global enable", irq, 0);
    wr('h04, 32'h1); chk("R9 irq high", irq, 1);
    wr('h0C, 32'h0); rd('h0C, 32'h1, "R8 write zero no change");
    wr('h0C, 32'h1); rd('h0C, 32'h0, "R8 toggle clears");
    chk("R9 irq low after clear", irq, 0);
    wr('h0C, 32'h2); chk("R9 irq from toggled ready bit", irq, 1);
    wr('h0C, 32'h2);
    wr('h08, 32'h0); pulse_done(); pulse_ready();
    rd('h0C, 32'h0, "R8 disabled events do not set");
    chk("R9 irq low when disabled", irq, 0);
    wr('h08, 32'h2); pulse_ready();
    rd('h0C, 32'h2, "R8 ready event sets bit 1");
    chk("R9 irq from ready source", irq, 1);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule